// File: doc/BRIEF.md
# Relay Short-Circuit Guard

This block sits between the wiper-style switch logic and the relay driver transistor. It passes the relay request to a registered drive output. It also watches a digital overcurrent flag produced by an external current sense. A fault counts only when the flag is high on three successive rising-edge samples taken while the drive is on. Once confirmed, a sticky fault latch forces the drive off. The latch stays set while any input switch is still closed. It is released only after every switch has been open for a programmable number of consecutive clock samples. After release, the relay can be driven again. If the overcurrent is still present at that point, it is caught and latched again by the same sequence.

A load-dump flag takes priority over the request and over the latch: while it is high, the drive is forced on so the transistor absorbs the surge, and detection is suspended. The active-low power-on reset clears everything and holds the drive off.

The block has no data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status level that is sampled or updated on the rising clock edge. The only exception is the internal confirmation chain, which advances on falling edges.

Top module: `relay_short_guard`

## Requirements
- R1: While `por_n` is low, `drive_out` and `fault_latched` are both 0.
- R2: With no fault latched and `ld_flag` low, `drive_out` equals the value of `relay_req` sampled at the previous rising edge.
- R3: `oc_flag` is ignored while `drive_out` is 0: holding it high with `relay_req` low for any time leaves `fault_latched` at 0.
- R4: If `oc_flag` is high at three consecutive rising-edge samples (edges 1, 2, 3) while the drive is on, then at edge 4 `fault_latched` becomes 1 and `drive_out` becomes 0. After edge 3, `drive_out` is still 1.
- R5: If `oc_flag` falls before its third consecutive high sample, the confirmation chain empties and `fault_latched` stays 0.
- R6: Once set, `fault_latched` stays 1 and `drive_out` stays 0 while `sw_any` is 1, whatever `relay_req` does.
- R7: `fault_latched` clears at the rising edge where `sw_any` has been sampled 0 for `RELEASE_CYCLES` consecutive edges. Any 1 sample restarts the count. The drive follows the request again one edge later.
- R8: After a release, a persisting overcurrent sets `fault_latched` again after three high samples, by the same sequence as R4.
- R9: `drive_out` is 1 at the edge after `ld_flag` is sampled high, even with `relay_req` low or the fault latched. No fault can be latched while `ld_flag` is high, and an existing latch is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples on rising edge, confirmation chain on falling edge |
| por_n | input | 1 | Active-low power-on reset, asynchronous assert |
| relay_req | input | 1 | Request to energize the relay |
| sw_any | input | 1 | High while any input switch is closed |
| oc_flag | input | 1 | Overcurrent indication from the current sense |
| ld_flag | input | 1 | Supply overvoltage (load dump) indication |
| drive_out | output | 1 | Registered relay transistor drive |
| fault_latched | output | 1 | Sticky short-circuit latch state |

## Verification
The drive output is a register, so a change on `relay_req` or `ld_flag` shows up exactly one rising edge later. The bench drives inputs one nanosecond after a rising edge and reads outputs one nanosecond after the next one. A persistent overcurrent is expected to latch on the fourth edge after the flag is raised. The bench checks the drive is still on after the third edge and off after the fourth. This also covers the worst-case spread of one extra clock when the flag arrives just after an edge. A release is expected on exactly the `RELEASE_CYCLES`-th edge of an open switch. The bench checks the cycle before and the cycle of the release, with a restart in between.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  // default number of consecutive overcurrent samples needed to confirm
  localparam int unsigned RSG_CONFIRM_DEF = 3;
  // default number of open-switch samples before the latch releases
  localparam int unsigned RSG_RELEASE_DEF = 8;
endpackage

// File: rtl/rsg_confirm.sv
module rsg_confirm #(
  parameter int unsigned DEPTH = rsg_pkg::RSG_CONFIRM_DEF
) (
  input  logic clk,
  input  logic por_n,
  input  logic arm,
  input  logic oc_flag,
  output logic confirmed
);
  logic             seen_q;
  logic [DEPTH-1:0] chain_q;

  // rising-edge sample of the overcurrent flag, only while armed
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) seen_q <= 1'b0;
    else        seen_q <= arm & oc_flag;
  end

  // falling-edge shift chain; an empty sample flushes every stage
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stage
    if (gi == 0) begin : g_head
      always_ff @(negedge clk or negedge por_n) begin
        if (!por_n) chain_q[gi] <= 1'b0;
        else        chain_q[gi] <= seen_q;
      end
    end else begin : g_tail
      always_ff @(negedge clk or negedge por_n) begin
        if (!por_n) chain_q[gi] <= 1'b0;
        else        chain_q[gi] <= seen_q & chain_q[gi-1];
      end
    end
  end

  assign confirmed = chain_q[DEPTH-1] & seen_q;
endmodule

// File: rtl/rsg_release.sv
module rsg_release #(
  parameter int unsigned HOLD = rsg_pkg::RSG_RELEASE_DEF
) (
  input  logic clk,
  input  logic por_n,
  input  logic sw_any,
  output logic done
);
  localparam int unsigned CW = (HOLD > 2) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           cnt_q <= '0;
    else if (sw_any)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  // true on the HOLD-th consecutive open sample
  assign done = !sw_any && (cnt_q == LAST);
endmodule

// File: rtl/relay_short_guard.sv
module relay_short_guard #(
  parameter int unsigned CONFIRM_DEPTH  = rsg_pkg::RSG_CONFIRM_DEF,
  parameter int unsigned RELEASE_CYCLES = rsg_pkg::RSG_RELEASE_DEF
) (
  input  logic clk,
  input  logic por_n,
  input  logic relay_req,
  input  logic sw_any,
  input  logic oc_flag,
  input  logic ld_flag,
  output logic drive_out,
  output logic fault_latched
);
  logic arm;
  logic confirmed;
  logic released;
  logic set_now;

  // detection only while the transistor is driven and no load dump
  assign arm = drive_out & ~ld_flag;

  rsg_confirm #(.DEPTH(CONFIRM_DEPTH)) u_confirm (
    .clk       (clk),
    .por_n     (por_n),
    .arm       (arm),
    .oc_flag   (oc_flag),
    .confirmed (confirmed)
  );

  rsg_release #(.HOLD(RELEASE_CYCLES)) u_release (
    .clk    (clk),
    .por_n  (por_n),
    .sw_any (sw_any),
    .done   (released)
  );

  assign set_now = confirmed & ~ld_flag;

  // sticky latch: setting wins over release
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        fault_latched <= 1'b0;
    else if (set_now)  fault_latched <= 1'b1;
    else if (released) fault_latched <= 1'b0;
  end

  // load dump forces conduction; a fault cuts the drive on the confirming edge
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) drive_out <= 1'b0;
    else        drive_out <= ld_flag | (relay_req & ~fault_latched & ~set_now);
  end
endmodule

// File: rtl/relay_short_guard_chk.sv
module relay_short_guard_chk (
  input logic clk,
  input logic por_n,
  input logic relay_req,
  input logic sw_any,
  input logic oc_flag,
  input logic ld_flag,
  input logic drive_out,
  input logic fault_latched
);
  // R9: load dump forces the drive on at the next edge
  assert_ld_forces_on_R9: assert property (@(posedge clk) disable iff (!por_n)
    ld_flag |=> drive_out);

  // R9: no new latch is set while load dump is active
  assert_no_set_in_ld_R9: assert property (@(posedge clk) disable iff (!por_n)
    ld_flag |=> !$rose(fault_latched));

  // R6: a latched fault keeps the drive off outside load dump
  assert_latch_blocks_R6: assert property (@(posedge clk) disable iff (!por_n)
    (fault_latched && !ld_flag) |=> !drive_out);

  // R6: latch survives while a switch is closed
  assert_latch_holds_R6: assert property (@(posedge clk) disable iff (!por_n)
    (fault_latched && sw_any) |=> fault_latched);

  // R7: latch only falls after an open-switch sample
  assert_release_open_R7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(fault_latched) |-> !$past(sw_any));

  // R3: latch only rises after the drive was on
  assert_set_needs_drive_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(fault_latched) |-> $past(drive_out));

  // R1: outputs low during reset
  always_comb begin
    if (!por_n) begin
      assert_por_clear_R1: assert (!drive_out && !fault_latched);
    end
  end

  logic unused_ok;
  assign unused_ok = relay_req ^ oc_flag;
endmodule

bind relay_short_guard relay_short_guard_chk u_chk (.*);

// File: tb/relay_short_guard_tb.sv
module relay_short_guard_tb;
  localparam int unsigned DEB = 8;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic relay_req = 1'b0;
  logic sw_any = 1'b0;
  logic oc_flag = 1'b0;
  logic ld_flag = 1'b0;
  logic drive_out;
  logic fault_latched;

  int nvec = 0;
  int nbad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  relay_short_guard #(.CONFIRM_DEPTH(3), .RELEASE_CYCLES(DEB)) u_dut (
    .clk           (clk),
    .por_n         (por_n),
    .relay_req     (relay_req),
    .sw_any        (sw_any),
    .oc_flag       (oc_flag),
    .ld_flag       (ld_flag),
    .drive_out     (drive_out),
    .fault_latched (fault_latched)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic t_reset_R1();
    por_n = 1'b0; relay_req = 1'b1; sw_any = 1'b1; ld_flag = 1'b0; oc_flag = 1'b0;
    step(3);
    chk(drive_out, 1'b0, "R1", "drive in reset");
    chk(fault_latched, 1'b0, "R1", "latch in reset");
    relay_req = 1'b0;
    por_n = 1'b1;
    step(1);
  endtask

  task automatic t_follow_R2();
    relay_req = 1'b1; step(1);
    chk(drive_out, 1'b1, "R2", "drive follows request on");
    relay_req = 1'b0; step(1);
    chk(drive_out, 1'b0, "R2", "drive follows request off");
  endtask

  task automatic t_ignore_idle_R3();
    relay_req = 1'b0; oc_flag = 1'b1; step(8);
    chk(fault_latched, 1'b0, "R3", "no latch with drive off");
    chk(drive_out, 1'b0, "R3", "drive stays off");
    oc_flag = 1'b0; step(1);
  endtask

  task automatic t_glitch_R5();
    relay_req = 1'b1; sw_any = 1'b1; step(1);
    oc_flag = 1'b1; step(2);
    oc_flag = 1'b0; step(6);
    chk(fault_latched, 1'b0, "R5", "short pulse not latched");
    chk(drive_out, 1'b1, "R5", "drive kept on");
  endtask

  task automatic t_confirm_R4();
    oc_flag = 1'b1; step(3);
    chk(drive_out, 1'b1, "R4", "drive still on after third sample");
    chk(fault_latched, 1'b0, "R4", "latch not yet set");
    step(1);
    chk(drive_out, 1'b0, "R4", "drive off on fourth edge");
    chk(fault_latched, 1'b1, "R4", "latch set on fourth edge");
  endtask

  task automatic t_hold_R6();
    oc_flag = 1'b0; relay_req = 1'b1; sw_any = 1'b1; step(20);
    chk(fault_latched, 1'b1, "R6", "latch held with switch closed");
    chk(drive_out, 1'b0, "R6", "drive held off");
  endtask

  task automatic t_release_R7();
    sw_any = 1'b0; step(DEB - 1);
    chk(fault_latched, 1'b1, "R7", "latch one edge before release");
    sw_any = 1'b1; step(1);
    sw_any = 1'b0; step(DEB - 1);
    chk(fault_latched, 1'b1, "R7", "count restarted by closed sample");
    step(1);
    chk(fault_latched, 1'b0, "R7", "latch released");
    chk(drive_out, 1'b0, "R7", "drive off on release edge");
    step(1);
    chk(drive_out, 1'b1, "R7", "drive resumes after release");
  endtask

  task automatic t_relatch_R8();
    sw_any = 1'b1; oc_flag = 1'b1; step(3);
    chk(drive_out, 1'b1, "R8", "drive on before reconfirm");
    step(1);
    chk(fault_latched, 1'b1, "R8", "latch set again");
    chk(drive_out, 1'b0, "R8", "drive off again");
  endtask

  task automatic t_loaddump_R9();
    ld_flag = 1'b1; step(1);
    chk(drive_out, 1'b1, "R9", "load dump drives over latch");
    chk(fault_latched, 1'b1, "R9", "latch kept in load dump");
    ld_flag = 1'b0; oc_flag = 1'b0; sw_any = 1'b0; relay_req = 1'b0; step(DEB + 1);
    chk(fault_latched, 1'b0, "R9", "latch released before clean dump test");
    ld_flag = 1'b1; oc_flag = 1'b1; sw_any = 1'b1; step(8);
    chk(drive_out, 1'b1, "R9", "drive forced with request low");
    chk(fault_latched, 1'b0, "R9", "no latch during load dump");
    ld_flag = 1'b0; oc_flag = 1'b0; step(1);
    chk(drive_out, 1'b0, "R9", "drive follows request after dump");
  endtask

  initial begin
    t_reset_R1();
    t_follow_R2();
    t_ignore_idle_R3();
    t_glitch_R5();
    t_confirm_R4();
    t_hold_R6();
    t_release_R7();
    t_relatch_R8();
    t_loaddump_R9();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule